// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This block gathers five interrupt causes for a small processor core: two external pins, two timer overflow flags, and a serial port whose receive and transmit flags share one entry. Each cause has its own enable bit. A global enable bit also gates every cause. Each cause carries one priority bit that places it in the high or the low level. The controller picks one eligible cause and presents a fixed vector address with a request line. It waits for the core to accept the request with an acknowledge pulse.

Once a request is accepted, its level is marked as in service. A later request of the same level, or of any level below it, is held off until the core sends a return-from-interrupt pulse. A high-level request may still interrupt a low-level routine. The external pins are active low and pass through a synchroniser. Each pin can be set to latch a falling edge, which the controller clears when that cause is vectored. Each pin can instead be set to follow the low level directly.

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset the request output is low, the vector output reads 0x0000, and no level is in service (`irq_active_o` = 00).
- R2: The vector presented for each cause is 0x0003 for external pin 0, 0x000B for timer 0, 0x0013 for external pin 1, 0x001B for timer 1, and 0x0023 for serial. Either the serial receive flag or the serial transmit flag alone raises the serial vector.
- R3: In `en_i`, bits 0 to 4 enable external 0, timer 0, external 1, timer 1 and serial, in that order. Bit 7 is the global enable. A cause is requested only when its own bit and bit 7 are both 1.
- R4: When several eligible causes share a level, the one chosen comes first in the order external 0, timer 0, external 1, timer 1, serial.
- R5: `prio_i` bit i places cause i (numbered as in R3) in the high level. An eligible high-level cause wins over any low-level cause. A high-level cause is requested even while a low-level routine is in service.
- R6: While the high level is in service, no request is made. While only the low level is in service, low-level causes are not requested. A return pulse ends the high level if it is in service, otherwise the low level. `irq_active_o` bit 1 shows the high level and bit 0 shows the low level.
- R7: With `ext_edge_i[k]` = 1, a falling edge on external pin k is latched. The latched flag stays pending after the pin returns high, and while the cause is masked. The flag is cleared when that cause's request is acknowledged.
- R8: With `ext_edge_i[k]` = 0, the external cause is pending exactly while the synchronised pin is low, and nothing is latched.
- R9: Drive an enabled edge-mode pin low just after a clock edge. The request appears after the fourth following edge, not before. In level mode it appears after the third edge.
- R10: An acknowledge given while the request is high drops the request on the next edge and marks the vector's level as in service. An acknowledge while the request is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n_i | input | 2 | External interrupt pins, active low, asynchronous |
| ext_edge_i | input | 2 | Per-pin trigger select: 1 falling edge, 0 low level |
| tmr_ovf_i | input | 2 | Timer 0 / timer 1 overflow flags (held by the timers) |
| ser_rx_i | input | 1 | Serial receive-complete flag |
| ser_tx_i | input | 1 | Serial transmit-complete flag |
| en_i | input | 8 | Enable bits; bit 7 global |
| prio_i | input | 5 | Per-cause high-priority bits |
| irq_ack_i | input | 1 | Core accepts the presented vector (one-cycle pulse) |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_req_o | output | 1 | Vector request to the core (registered) |
| irq_vec_o | output | 16 | Vector address (registered; 0 when idle) |
| irq_active_o | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The assertions assume that the core raises `irq_ack_i` only as a single-cycle pulse. They also assume that it sends `reti_i` only while some level is in service, as a real core would after completing a routine. The bench drives acknowledge and return as one-cycle pulses through tasks that keep to this rule. It issues an acknowledge only after it has observed the request high. The only exception is one deliberate stray acknowledge made while the request is low. Timer and serial flags are driven as levels held by their own units, so the bench changes them only between checks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC  = 5;
  localparam int SRC_W = $clog2(NSRC);
  localparam int NEXT  = 2;

  typedef logic [SRC_W-1:0] src_idx_t;

  typedef enum logic [SRC_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  // Source index for external pin k: external pins sit on even slots.
  function automatic src_idx_t ext_slot(input int k);
    return src_idx_t'(2 * k);
  endfunction
endpackage

// File: rtl/irqc_ext_sync.sv
module irqc_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [STAGES-1:0] shreg_q;
  logic              prev_q;
  logic              latch_q;
  logic              synced;
  logic              fall;

  assign synced = shreg_q[STAGES-1];
  assign fall   = prev_q & ~synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '1;
      prev_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      shreg_q <= {shreg_q[STAGES-2:0], pin_n_i};
      prev_q  <= synced;
      if (!edge_mode_i)
        latch_q <= 1'b0;
      else if (fall)
        latch_q <= 1'b1;
      else if (clr_i)
        latch_q <= 1'b0;
    end
  end

  assign flag_o = edge_mode_i ? latch_q : ~synced;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] prio_i,
  input  logic         ins_hi_i,
  input  logic         ins_lo_i,
  output logic         valid_o,
  output src_idx_t     idx_o,
  output logic         hi_o
);
  logic [N-1:0] elig_hi, elig_lo;
  src_idx_t     hi_idx, lo_idx;

  assign elig_hi = pend_i &  prio_i & {N{~ins_hi_i}};
  assign elig_lo = pend_i & ~prio_i & {N{~ins_hi_i & ~ins_lo_i}};

  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (elig_hi[i]) hi_idx = src_idx_t'(i);
      if (elig_lo[i]) lo_idx = src_idx_t'(i);
    end
  end

  always_comb begin
    if (|elig_hi) begin
      valid_o = 1'b1;
      idx_o   = hi_idx;
      hi_o    = 1'b1;
    end else if (|elig_lo) begin
      valid_o = 1'b1;
      idx_o   = lo_idx;
      hi_o    = 1'b0;
    end else begin
      valid_o = 1'b0;
      idx_o   = '0;
      hi_o    = 1'b0;
    end
  end
endmodule

// File: rtl/irqc_nest.sv
module irqc_nest (
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  input  logic take_hi_i,
  input  logic reti_i,
  output logic ins_hi_o,
  output logic ins_lo_o
);
  logic hi_q, lo_q, hi_n, lo_n;

  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    if (reti_i) begin
      if (hi_q) hi_n = 1'b0;
      else      lo_n = 1'b0;
    end
    if (take_i) begin
      if (take_hi_i) hi_n = 1'b1;
      else           lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end

  assign ins_hi_o = hi_q;
  assign ins_lo_o = lo_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int SYNC_ST    = 2,
  parameter int EN_W       = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NEXT-1:0]    ext_n_i,
  input  logic [NEXT-1:0]    ext_edge_i,
  input  logic [1:0]         tmr_ovf_i,
  input  logic               ser_rx_i,
  input  logic               ser_tx_i,
  input  logic [EN_W-1:0]    en_i,
  input  logic [NSRC-1:0]    prio_i,
  input  logic               irq_ack_i,
  input  logic               reti_i,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic [1:0]         irq_active_o
);
  localparam int GLOBAL_BIT = EN_W - 1;

  logic [NEXT-1:0] ext_flag;
  logic [NSRC-1:0] pend, masked;
  logic            win_valid, win_hi;
  src_idx_t        win_idx;
  logic            ins_hi, ins_lo;
  logic            take;

  logic             req_q, hi_q;
  src_idx_t         src_q;
  logic [VEC_W-1:0] vec_q;

  assign take = irq_ack_i & req_q;

  for (genvar k = 0; k < NEXT; k++) begin : g_ext
    irqc_ext_sync #(.STAGES(SYNC_ST)) u_sync (
      .clk         (clk),
      .rst         (rst),
      .pin_n_i     (ext_n_i[k]),
      .edge_mode_i (ext_edge_i[k]),
      .clr_i       (take && (src_q == ext_slot(k))),
      .flag_o      (ext_flag[k])
    );
  end

  assign pend[SRC_EXT0] = ext_flag[0];
  assign pend[SRC_TMR0] = tmr_ovf_i[0];
  assign pend[SRC_EXT1] = ext_flag[1];
  assign pend[SRC_TMR1] = tmr_ovf_i[1];
  assign pend[SRC_SER]  = ser_rx_i | ser_tx_i;

  assign masked = pend & en_i[NSRC-1:0] & {NSRC{en_i[GLOBAL_BIT]}};

  irqc_arbiter #(.N(NSRC)) u_arb (
    .pend_i   (masked),
    .prio_i   (prio_i),
    .ins_hi_i (ins_hi),
    .ins_lo_i (ins_lo),
    .valid_o  (win_valid),
    .idx_o    (win_idx),
    .hi_o     (win_hi)
  );

  irqc_nest u_nest (
    .clk       (clk),
    .rst       (rst),
    .take_i    (take),
    .take_hi_i (hi_q),
    .reti_i    (reti_i),
    .ins_hi_o  (ins_hi),
    .ins_lo_o  (ins_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      hi_q  <= 1'b0;
      src_q <= '0;
      vec_q <= '0;
    end else begin
      req_q <= win_valid & ~take;
      hi_q  <= win_hi;
      src_q <= win_idx;
      vec_q <= (win_valid & ~take)
               ? VEC_W'(VEC_BASE + VEC_STRIDE * int'(win_idx))
               : '0;
    end
  end

  assign irq_req_o    = req_q;
  assign irq_vec_o    = vec_q;
  assign irq_active_o = {ins_hi, ins_lo};
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int VEC_W = 16,
  parameter int EN_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_ack_i,
  input logic [EN_W-1:0]  en_i,
  input logic             irq_req_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [1:0]       irq_active_o
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!irq_req_o && irq_vec_o == '0 && irq_active_o == 2'b00));

  a_r10_ack_drops_req: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_i && irq_req_o) |=> !irq_req_o);

  a_r10_ack_marks_level: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_i && irq_req_o) |=> (irq_active_o != 2'b00));

  a_r3_global_off_no_req: assert property (@(posedge clk) disable iff (rst)
    !en_i[EN_W-1] |=> !irq_req_o);

  a_r6_high_blocks_all: assert property (@(posedge clk) disable iff (rst)
    irq_active_o[1] |=> !irq_req_o);

  a_r2_vector_legal: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> (irq_vec_o[2:0] == 3'd3 && irq_vec_o <= VEC_W'(16'h0023)));
endmodule

bind irqc_top irqc_checker #(.VEC_W(VEC_W), .EN_W(EN_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .irq_ack_i    (irq_ack_i),
  .en_i         (en_i),
  .irq_req_o    (irq_req_o),
  .irq_vec_o    (irq_vec_o),
  .irq_active_o (irq_active_o)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  ext_edge = 2'b00;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_rx = 1'b0, ser_tx = 1'b0;
  logic [7:0]  en = 8'h00;
  logic [4:0]  prio = 5'b0;
  logic        ack = 1'b0, reti = 1'b0;
  logic        req;
  logic [15:0] vec;
  logic [1:0]  act;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst(rst), .ext_n_i(ext_n), .ext_edge_i(ext_edge),
    .tmr_ovf_i(tmr_ovf), .ser_rx_i(ser_rx), .ser_tx_i(ser_tx),
    .en_i(en), .prio_i(prio), .irq_ack_i(ack), .reti_i(reti),
    .irq_req_o(req), .irq_vec_o(vec), .irq_active_o(act)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input int actual, input int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  // bit0 ext0 (level, pin low), bit1 tmr0, bit2 ext1 (level), bit3 tmr1, bit4 serial rx
  task automatic set_pend(input logic [4:0] m);
    ext_n[0]   = ~m[0];
    tmr_ovf[0] = m[1];
    ext_n[1]   = ~m[2];
    tmr_ovf[1] = m[3];
    ser_rx     = m[4];
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  function automatic int first_set(input logic [4:0] m);
    for (int i = 0; i < 5; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int vec_for(input int i);
    return (i < 0) ? 0 : 3 + 8 * i;
  endfunction

  task automatic do_reset();
    rst = 1'b1; tick(2); rst = 1'b0; tick();
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check("R1 req after reset", req, 0);
    check("R1 vec after reset", vec, 0);
    check("R1 active after reset", act, 0);

    // R2 each source alone, levels, all low priority
    en = 8'h9F; prio = 5'b0; ext_edge = 2'b00;
    for (int s = 0; s < 5; s++) begin
      set_pend(5'(1 << s)); tick(4);
      check($sformatf("R2 src%0d req", s), req, 1);
      check($sformatf("R2 src%0d vec", s), vec, vec_for(s));
    end
    set_pend(5'b0); ser_tx = 1'b1; tick(4);
    check("R2 serial tx alone vec", vec, 16'h0023);
    ser_tx = 1'b0; tick(4);
    check("R2 idle vec zero", vec, 0);

    // R4 exhaustive same-level order
    for (int m = 0; m < 32; m++) begin
      set_pend(5'(m)); tick(4);
      check($sformatf("R4 order pend=%0h req", m), req, (m != 0) ? 1 : 0);
      check($sformatf("R4 order pend=%0h vec", m), vec, vec_for(first_set(5'(m))));
    end

    // R3 exhaustive own enables, all pending, global on
    set_pend(5'h1F);
    for (int e = 0; e < 32; e++) begin
      en = {3'b100, 5'(e)}; tick(3);
      check($sformatf("R3 enables=%0h vec", e), vec, vec_for(first_set(5'(e))));
    end
    // R3 global off masks every pattern
    for (int e = 0; e < 32; e++) begin
      en = {3'b000, 5'(e)}; tick(3);
      check($sformatf("R3 global off en=%0h req", e), req, 0);
    end
    en = 8'h9F;

    // R5 exhaustive priority masks, all pending
    for (int p = 0; p < 32; p++) begin
      prio = 5'(p); tick(3);
      check($sformatf("R5 prio=%0h vec", p), vec,
            vec_for((p != 0) ? first_set(5'(p)) : 0));
    end

    // R6/R10 nesting
    prio = 5'b0; set_pend(5'b00010); tick(4);
    check("R10 req before ack", req, 1);
    pulse_ack();
    check("R10 req drops after ack", req, 0);
    check("R10 low level marked", act, 2'b01);
    tick(3);
    check("R6 same level blocked", req, 0);
    prio = 5'b01000; set_pend(5'b01010); tick(3);
    check("R5 high preempts low req", req, 1);
    check("R5 high preempts low vec", vec, 16'h001B);
    pulse_ack();
    check("R6 both levels active", act, 2'b11);
    tick(3);
    check("R6 high in service blocks", req, 0);
    set_pend(5'b00010);
    pulse_reti();
    check("R6 reti ends high first", act, 2'b01);
    tick(3);
    check("R6 low still blocks low", req, 0);
    pulse_reti();
    check("R6 reti ends low", act, 2'b00);
    tick(2);
    check("R6 low served again", vec, 16'h000B);
    set_pend(5'b0); tick(3);
    ack = 1'b1; tick(); ack = 1'b0;
    check("R10 stray ack ignored", act, 2'b00);

    // R9 latency, edge mode, R7 latch and auto-clear
    do_reset();
    en = 8'h9F; prio = 5'b0; ext_edge = 2'b11;
    ext_n[0] = 1'b0; tick(3);
    check("R9 edge no req after third edge", req, 0);
    tick();
    check("R9 edge req after fourth edge", req, 1);
    ext_n[0] = 1'b1; tick(4);
    check("R7 edge latched after pin high", vec, 16'h0003);
    pulse_ack(); tick(4);
    pulse_reti(); tick(4);
    check("R7 flag cleared on ack", req, 0);
    en = 8'h1F;
    ext_n[1] = 1'b0; tick(); ext_n[1] = 1'b1; tick(5);
    check("R7 masked no req", req, 0);
    en = 8'h9F; tick(2);
    check("R7 latched while masked", vec, 16'h0013);
    pulse_ack(); pulse_reti(); tick(4);
    check("R7 ext1 cleared", req, 0);

    // R9 level latency, R8 not latched
    ext_edge = 2'b00;
    ext_n[0] = 1'b0; tick(2);
    check("R9 level no req after second edge", req, 0);
    tick();
    check("R9 level req after third edge", req, 1);
    ext_n[0] = 1'b1; tick(4);
    check("R8 level not latched", req, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule